// File: doc/BRIEF.md
# Video Line ID Word Decoder

This block recovers a short identification word that a broadcaster places on one vertical-blanking line of each field of an NTSC picture. It sees the picture only as a sliced data bit plus sync strobes, all sampled on the 4x subcarrier clock (14.318 MHz). A line counter, restarted by every vertical strobe, finds the carrier line of each field. On that line a bit sampler locks to a reference start edge and reads a 20-bit word: 14 data bits, then a 6-bit CRC. Words that pass the CRC are compared from one field to the next. Only a word that agrees across two consecutive fields is published.

The published 14 data bits and a separate validity flag come out side by side. Two convenience outputs give the aspect bit and the letter-box bit, each gated by the validity flag. Control inputs choose a strict or a tolerant line window and choose whether the result is held through a run of bad fields. A soft reset clears the decoder after a change of input source.

Top module: `vid_id_decoder`

## Requirements
- R1: After rst_ni is released, id_data_o, valid_o, wide_o and lbox_o are all 0.
- R2: Within an accepted line, the first rising edge of data_i that falls 40 to 200 clocks after the line start begins a reference cell. Twenty 32-clock cells follow, each sampled at its middle. The first 14 cells are data bits, sent first-to-last into id_data_o[0] up to id_data_o[13]. The last 6 cells are the CRC, sent most significant bit first.
- R3: The CRC uses the generator x^6+x+1, is preset to all ones, and is shifted over the 14 data bits in the order they are sent. A word whose received CRC differs from the computed one is discarded, and its field counts as a field with no good word.
- R4: A vertical strobe with field_i=0 makes the next line line 1; with field_i=1 it makes the next line line 264. The nominal carrier line is 20 in the first field and 283 in the second.
- R5: With strict_i=0, a word on the nominal line or on the line just before or after it is accepted. With strict_i=1, only the nominal line is accepted, and words on the neighbouring lines are ignored.
- R6: Results change only at a vertical strobe. If the field that just ended and the field before it each gave a good word, and the two words are equal, id_data_o takes that word and valid_o goes to 1.
- R7: With no_hold_i=0, each field with no good word adds one to a miss count, and a good word resets the count. When the count reaches MISS_LIMIT (default 3), valid_o drops. id_data_o keeps the last published word.
- R8: With no_hold_i=1, a single field with no good word clears valid_o and id_data_o to 0 at the strobe that ends it.
- R9: A one-cycle soft_rst_i clears id_data_o, valid_o, the miss count and any word captured in the current field. After it, two new agreeing fields are needed before valid_o rises again.
- R10: wide_o equals valid_o AND id_data_o[0] (1 means 16:9). lbox_o equals valid_o AND id_data_o[1] (1 means letter-box).
- R11: A good word that differs from the previous field's word leaves id_data_o and valid_o unchanged. The new word is published only when the following field repeats it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4x subcarrier clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 1 | Sliced data bit |
| hsync_i | input | 1 | One-cycle horizontal sync strobe at the start of a line |
| vsync_i | input | 1 | One-cycle vertical sync strobe at the start of a field |
| field_i | input | 1 | Field parity, sampled with vsync_i (0 first, 1 second) |
| strict_i | input | 1 | 1 accepts only the nominal line |
| no_hold_i | input | 1 | 1 disables holding through bad fields |
| soft_rst_i | input | 1 | Synchronous decoder clear |
| id_data_o | output | 14 | Published data bits |
| valid_o | output | 1 | Validity flag |
| wide_o | output | 1 | 16:9 flag gated by validity |
| lbox_o | output | 1 | Letter-box flag gated by validity |

## Verification
The hardest states to reach from the ports depend on the history of several fields. These are the hold count running out after exactly MISS_LIMIT bad fields, a changed word that must wait for a second agreeing field, and a word placed on a neighbouring line while the strict window is set. The bench drives whole fields: a vertical strobe, then short filler lines, then one full-length line carrying a bit-serial word with a CRC built in the bench. For each field it chooses the line offset, CRC corruption, window mode and hold mode. Directed field sequences reach each history. A seeded random run then mixes offsets, corrupt CRCs and a small set of repeating words, so that agreements, changes and misses come up often. After every field boundary the bench compares the outputs against its own model of the requirements.

// File: rtl/vid_id_pkg.sv
package vid_id_pkg;
  localparam int DATA_W = 14;
  localparam int CRC_W  = 6;
  localparam int WORD_W = DATA_W + CRC_W;

  localparam logic [CRC_W-1:0] CRC_POLY = 6'h03;  // x^6 + x + 1
  localparam logic [CRC_W-1:0] CRC_INIT = 6'h3f;

  typedef enum logic [1:0] {
    SMP_IDLE,
    SMP_SEEK,
    SMP_RECV,
    SMP_CHECK
  } smp_state_e;

  function automatic logic [CRC_W-1:0] crc6_calc(input logic [DATA_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = CRC_INIT;
    for (int i = 0; i < DATA_W; i++) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction
endpackage

// File: rtl/vid_line_tracker.sv
module vid_line_tracker #(
  parameter int LINE_W  = 10,
  parameter int F1_BASE = 263,
  parameter int NOM_F0  = 20,
  parameter int NOM_F1  = 283
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  input  logic vsync_i,
  input  logic field_i,
  input  logic strict_i,
  output logic line_go_o,
  output logic in_win_o
);
  localparam logic [LINE_W-1:0] NOM0 = LINE_W'(NOM_F0);
  localparam logic [LINE_W-1:0] NOM1 = LINE_W'(NOM_F1);
  localparam logic [LINE_W-1:0] BASE1 = LINE_W'(F1_BASE);

  logic [LINE_W-1:0] line_q, nxt, nom;
  logic fld_q, go_q, win_q, strict_q, win_c;

  always_comb begin
    nxt = line_q + 1'b1;
    nom = fld_q ? NOM1 : NOM0;
    if (strict_i) win_c = (nxt == nom);
    else          win_c = (nxt >= nom - 1'b1) && (nxt <= nom + 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q   <= '0;
      fld_q    <= 1'b0;
      go_q     <= 1'b0;
      win_q    <= 1'b0;
      strict_q <= 1'b0;
    end else if (vsync_i) begin
      line_q <= field_i ? BASE1 : '0;
      fld_q  <= field_i;
      go_q   <= 1'b0;
      win_q  <= 1'b0;
    end else if (hsync_i) begin
      line_q   <= nxt;
      go_q     <= 1'b1;
      win_q    <= win_c;
      strict_q <= strict_i;
    end else begin
      go_q <= 1'b0;
    end
  end

  assign line_go_o = go_q;
  assign in_win_o  = win_q;

  // R5: strict window opens on the nominal line only
  a_r5_strict_nominal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_q && win_q && strict_q) |-> (line_q == nom));
  // R5: tolerant window never exceeds one line either side
  a_r5_tol_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_q && win_q) |-> ((line_q + 1'b1 >= nom) && (line_q <= nom + 1'b1)));
endmodule

// File: rtl/vid_bit_sampler.sv
module vid_bit_sampler
  import vid_id_pkg::*;
#(
  parameter int CELL   = 32,
  parameter int WIN_LO = 40,
  parameter int WIN_HI = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              data_i,
  input  logic              line_go_i,
  input  logic              in_win_i,
  output logic              word_ok_o,
  output logic [DATA_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WIN_HI + 2);
  localparam int PH_W  = $clog2(CELL + CELL / 2 + 1);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LO    = CNT_W'(WIN_LO);
  localparam logic [CNT_W-1:0] CNT_HI    = CNT_W'(WIN_HI);
  localparam logic [PH_W-1:0]  PH_SAMPLE = PH_W'(CELL + CELL / 2);
  localparam logic [PH_W-1:0]  PH_RELOAD = PH_W'(CELL / 2 + 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(WORD_W - 1);

  smp_state_e state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PH_W-1:0]   ph_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] sh_q;
  logic [CRC_W-1:0]  rx_crc;
  logic data_q, ok_q;
  logic [DATA_W-1:0] word_q;

  // CRC arrives msb first after the data
  always_comb begin
    for (int j = 0; j < CRC_W; j++) rx_crc[CRC_W-1-j] = sh_q[DATA_W+j];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SMP_IDLE;
      cnt_q   <= '0;
      ph_q    <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      data_q  <= 1'b0;
      ok_q    <= 1'b0;
      word_q  <= '0;
    end else begin
      data_q <= data_i;
      ok_q   <= 1'b0;
      if (soft_rst_i) begin
        state_q <= SMP_IDLE;
        word_q  <= '0;
      end else if (line_go_i) begin
        state_q <= in_win_i ? SMP_SEEK : SMP_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          SMP_SEEK: begin
            if (data_i && !data_q && cnt_q >= CNT_LO) begin
              state_q <= SMP_RECV;
              ph_q    <= PH_W'(1);
              idx_q   <= '0;
            end else if (cnt_q == CNT_HI) begin
              state_q <= SMP_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          SMP_RECV: begin
            if (ph_q == PH_SAMPLE) begin
              sh_q[idx_q] <= data_i;
              ph_q        <= PH_RELOAD;
              if (idx_q == IDX_LAST) state_q <= SMP_CHECK;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
          SMP_CHECK: begin
            ok_q    <= (crc6_calc(sh_q[DATA_W-1:0]) == rx_crc);
            word_q  <= sh_q[DATA_W-1:0];
            state_q <= SMP_IDLE;
          end
          default: state_q <= SMP_IDLE;
        endcase
      end
    end
  end

  assign word_ok_o = ok_q;
  assign word_o    = word_q;

  // R2: a word starts only inside the start window
  a_r2_start_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SMP_RECV && $past(state_q) == SMP_SEEK) |->
      ($past(cnt_q) >= CNT_LO && $past(cnt_q) <= CNT_HI));
  // R2: bit index stays within the word
  a_r2_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SMP_RECV) |-> (idx_q <= IDX_LAST));
  // R3: a good-word strobe follows a completed 20-bit capture
  a_r3_ok_after_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_q |-> ($past(state_q) == SMP_CHECK));
endmodule

// File: rtl/vid_field_judge.sv
module vid_field_judge #(
  parameter int DATA_W     = 14,
  parameter int MISS_LIMIT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              vsync_i,
  input  logic              no_hold_i,
  input  logic              word_ok_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [MISS_W-1:0] MISS_MAX = MISS_W'(MISS_LIMIT);

  logic [DATA_W-1:0] cap_q, prev_q, data_q;
  logic got_q, prev_ok_q, valid_q;
  logic [MISS_W-1:0] miss_q, miss_n;

  assign miss_n = (miss_q == MISS_MAX) ? MISS_MAX : miss_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q     <= '0;
      prev_q    <= '0;
      data_q    <= '0;
      got_q     <= 1'b0;
      prev_ok_q <= 1'b0;
      valid_q   <= 1'b0;
      miss_q    <= '0;
    end else if (soft_rst_i) begin
      cap_q     <= '0;
      prev_q    <= '0;
      data_q    <= '0;
      got_q     <= 1'b0;
      prev_ok_q <= 1'b0;
      valid_q   <= 1'b0;
      miss_q    <= '0;
    end else if (vsync_i) begin
      got_q <= 1'b0;
      if (got_q) begin
        if (prev_ok_q && prev_q == cap_q) begin
          data_q  <= cap_q;
          valid_q <= 1'b1;
        end
        prev_q    <= cap_q;
        prev_ok_q <= 1'b1;
        miss_q    <= '0;
      end else begin
        prev_ok_q <= 1'b0;
        if (no_hold_i) begin
          data_q  <= '0;
          valid_q <= 1'b0;
          miss_q  <= '0;
        end else begin
          miss_q <= miss_n;
          if (miss_n >= MISS_MAX) valid_q <= 1'b0;
        end
      end
    end else if (word_ok_i && !got_q) begin
      got_q <= 1'b1;  // first good word of the field wins
      cap_q <= word_i;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  // R6: validity rises only at a field boundary that closed a good field
  a_r6_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(vsync_i && got_q && prev_ok_q));
  // R7: holding keeps the published word through a bad field
  a_r7_hold_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_i && !soft_rst_i && !got_q && !no_hold_i) |=> $stable(data_q));
  // R8: without hold, one bad field clears everything
  a_r8_no_hold_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_i && !soft_rst_i && !got_q && no_hold_i) |=> (!valid_q && data_q == '0));
  // R9: soft reset empties the result and the capture
  a_r9_soft_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!valid_q && data_q == '0 && !got_q && miss_q == '0));
  // R11: a new nonzero word appears only after agreement
  a_r11_change_agreed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(data_q) && data_q != '0) |-> $past(vsync_i && got_q && prev_ok_q && prev_q == cap_q));
endmodule

// File: rtl/vid_id_decoder.sv
module vid_id_decoder
  import vid_id_pkg::*;
#(
  parameter int CELL       = 32,
  parameter int WIN_LO     = 40,
  parameter int WIN_HI     = 200,
  parameter int MISS_LIMIT = 3,
  parameter int LINE_W     = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_i,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              field_i,
  input  logic              strict_i,
  input  logic              no_hold_i,
  input  logic              soft_rst_i,
  output logic [DATA_W-1:0] id_data_o,
  output logic              valid_o,
  output logic              wide_o,
  output logic              lbox_o
);
  logic line_go, in_win, word_ok;
  logic [DATA_W-1:0] word;

  vid_line_tracker #(
    .LINE_W (LINE_W),
    .F1_BASE(263),
    .NOM_F0 (20),
    .NOM_F1 (283)
  ) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hsync_i  (hsync_i),
    .vsync_i  (vsync_i),
    .field_i  (field_i),
    .strict_i (strict_i),
    .line_go_o(line_go),
    .in_win_o (in_win)
  );

  vid_bit_sampler #(
    .CELL  (CELL),
    .WIN_LO(WIN_LO),
    .WIN_HI(WIN_HI)
  ) u_smp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .data_i    (data_i),
    .line_go_i (line_go),
    .in_win_i  (in_win),
    .word_ok_o (word_ok),
    .word_o    (word)
  );

  vid_field_judge #(
    .DATA_W    (DATA_W),
    .MISS_LIMIT(MISS_LIMIT)
  ) u_judge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .vsync_i   (vsync_i),
    .no_hold_i (no_hold_i),
    .word_ok_i (word_ok),
    .word_i    (word),
    .data_o    (id_data_o),
    .valid_o   (valid_o)
  );

  assign wide_o = valid_o & id_data_o[0];
  assign lbox_o = valid_o & id_data_o[1];

  // R10: gated flags never stand without validity
  a_r10_flags_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_o || lbox_o) |-> valid_o);
endmodule

// File: tb/vid_id_decoder_tb_top.sv
module vid_id_decoder_tb_top;
  localparam int MISS_LIMIT = 3;
  localparam int LEAD = 80;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic data_i = 1'b0, hsync_i = 1'b0, vsync_i = 1'b0, field_i = 1'b0;
  logic strict_i = 1'b0, no_hold_i = 1'b0, soft_rst_i = 1'b0;
  logic [13:0] id_data_o;
  logic valid_o, wide_o, lbox_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  logic [13:0] exp_data = '0;
  bit exp_valid = 0, m_prev_ok = 0, pend_got = 0;
  logic [13:0] m_prev = '0, pend_word = '0;
  int m_miss = 0;

  always #5 clk = ~clk;

  vid_id_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .hsync_i(hsync_i),
    .vsync_i(vsync_i), .field_i(field_i), .strict_i(strict_i),
    .no_hold_i(no_hold_i), .soft_rst_i(soft_rst_i), .id_data_o(id_data_o),
    .valid_o(valid_o), .wide_o(wide_o), .lbox_o(lbox_o)
  );

  function automatic logic [5:0] ref_crc(input logic [13:0] d);
    logic [5:0] r = 6'b111111;
    for (int i = 0; i < 14; i++) begin
      if (r[5] != d[i]) r = (r << 1) ^ 6'b000011;
      else              r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [19:0] mk_frame(input logic [13:0] d, input bit corrupt);
    logic [19:0] f;
    logic [5:0] c = ref_crc(d);
    f[13:0] = d;
    for (int j = 0; j < 6; j++) f[14+j] = c[5-j];
    if (corrupt) f[19] = ~f[19];
    return f;
  endfunction

  function automatic bit line_ok(input bit fld, input int ln, input bit strict);
    int nom = fld ? 283 : 20;
    if (strict) return ln == nom;
    return (ln >= nom - 1) && (ln <= nom + 1);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    check(tag, 32'(id_data_o), 32'(exp_data));
    check(tag, 32'(valid_o), 32'(exp_valid));
    check("R10", 32'(wide_o), 32'(exp_valid & exp_data[0]));
    check("R10", 32'(lbox_o), 32'(exp_valid & exp_data[1]));
  endtask

  task automatic model_eval();
    if (pend_got) begin
      if (m_prev_ok && m_prev == pend_word) begin
        exp_data = pend_word;
        exp_valid = 1;
      end
      m_miss = 0;
      m_prev = pend_word;
      m_prev_ok = 1;
    end else begin
      m_prev_ok = 0;
      if (no_hold_i) begin
        exp_data = '0; exp_valid = 0; m_miss = 0;
      end else begin
        if (m_miss < MISS_LIMIT) m_miss++;
        if (m_miss >= MISS_LIMIT) exp_valid = 0;
      end
    end
    pend_got = 0;
  endtask

  task automatic short_line();
    hsync_i = 1; tick(1); hsync_i = 0; tick(3);
  endtask

  task automatic data_line(input logic [19:0] f);
    hsync_i = 1; tick(1); hsync_i = 0;
    tick(LEAD);
    data_i = 1; tick(32);
    for (int k = 0; k < 20; k++) begin
      data_i = f[k]; tick(32);
    end
    data_i = 0; tick(16);
  endtask

  // one field: strobe, check the boundary, then lines 1..22 of the field
  task automatic run_field(input string tag, input bit fld, input int wline,
                           input logic [13:0] d, input bit corrupt);
    int base = fld ? 263 : 0;
    field_i = fld; vsync_i = 1; tick(1); vsync_i = 0;
    model_eval();
    tick(2);
    check_all(tag);
    if (wline != 0 && line_ok(fld, wline, strict_i) && !corrupt) begin
      pend_got = 1; pend_word = d;
    end
    for (int n = 1; n <= 22; n++) begin
      if (base + n == wline) data_line(mk_frame(d, corrupt));
      else short_line();
    end
  endtask

  task automatic soft_reset();
    soft_rst_i = 1; tick(1); soft_rst_i = 0; tick(1);
    exp_data = '0; exp_valid = 0; m_prev_ok = 0; m_miss = 0; pend_got = 0;
    check_all("R9");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int r;
    logic [13:0] pool [3];
    void'($urandom(32'd1234));
    tick(3);
    rst_ni = 1;
    tick(2);
    check_all("R1");

    // R2 R4 R6: same word on both nominal lines
    run_field("R1", 0, 20, 14'h2a53, 0);
    run_field("R4", 1, 283, 14'h2a53, 0);
    run_field("R6", 0, 20, 14'h2a53, 0);
    // R11: word change needs two fields
    run_field("R6", 1, 283, 14'h1e01, 0);
    run_field("R11", 0, 20, 14'h1e01, 0);
    // R3 R7: corrupted CRCs are misses, hold until limit
    run_field("R11", 1, 283, 14'h1e01, 1);
    run_field("R3", 0, 20, 14'h1e01, 1);
    run_field("R7", 1, 0, '0, 0);
    run_field("R7", 0, 0, '0, 0);
    // R5 tolerant: one line early then one line late
    run_field("R7", 1, 282, 14'h0ffe, 0);
    run_field("R5", 0, 21, 14'h0ffe, 0);
    run_field("R5", 1, 283, 14'h0ffe, 0);
    // R5 strict with R8 no hold
    strict_i = 1; no_hold_i = 1;
    run_field("R5", 0, 20, 14'h3003, 0);
    run_field("R5", 1, 283, 14'h3003, 0);
    run_field("R5", 0, 19, 14'h0555, 0);
    run_field("R8", 1, 283, 14'h0555, 0);
    run_field("R8", 0, 20, 14'h0555, 0);
    strict_i = 0; no_hold_i = 0;
    // R9: soft reset drops result and history
    run_field("R5", 1, 283, 14'h0555, 0);
    soft_reset();
    run_field("R9", 0, 20, 14'h0002, 0);
    run_field("R9", 1, 283, 14'h0002, 0);
    run_field("R9", 0, 20, 14'h0002, 0);

    // random mix
    pool[0] = 14'($urandom); pool[1] = 14'($urandom); pool[2] = 14'h0003;
    for (int i = 0; i < 22; i++) begin
      bit fld = i[0];
      int off;
      r = int'($urandom_range(0, 9));
      strict_i = ($urandom_range(0, 3) == 0);
      no_hold_i = ($urandom_range(0, 4) == 0);
      off = int'($urandom_range(0, 4)) - 2;
      run_field("R6", fld, (r == 0) ? 0 : (fld ? 283 : 20) + off,
                pool[$urandom_range(0, 2)], ($urandom_range(0, 3) == 0));
    end
    strict_i = 0; no_hold_i = 0;
    run_field("R6", 0, 0, '0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule